// File: doc/BRIEF.md
# Translation Buffer Entry Store with One-Bit LRU Replacement

This block holds the entries of a fully associative address-translation buffer and manages how they are written and invalidated. Each entry pairs a virtual tag with a translation word. The translation word carries a valid flag, a 2-bit page-size code, a lock flag and a used flag. Software first loads a tag-access register with the virtual tag. It then either writes a translation word into an entry chosen by address (indexed write), or lets the block pick a victim entry (data-in write). Victim choice prefers empty slots. After that it prefers unlocked entries not marked used, and only then unlocked entries marked used.

When a write replaces an entry that was valid, the block reports the page range that entry covered on a flush output for one cycle. An owner can then drop any cached state for that range. A demap request invalidates every valid entry whose page contains a given virtual address. Every operation completes in a single clock cycle, so the block never stalls. Lookup and page-table walking are handled elsewhere. A combinational read port exposes any entry.

Top module: `tlb_lru_store`

## Requirements
- R1: After reset every entry reads back with tag zero and translation word zero, and flush_valid and full_err are low.
- R2: A tag write loads tag_wdata into the tag-access register. Every later entry write stores that register's value as the entry's tag. The register holds its value until the next tag write.
- R3: An indexed write (idx_we) stores wr_data and the tag-access value into entry wr_addr[8:3]. Address bits [2:0] are ignored. The entry is visible on the read port after the next rising edge.
- R4: A data-in write (din_we) chooses the lowest-numbered entry whose valid bit (translation word bit 63) is zero, if there is one.
- R5: If all entries are valid, a data-in write chooses the lowest-numbered entry whose lock bit (bit 6) is zero and whose used bit (bit 7) is zero.
- R6: If all unlocked entries have used set, a data-in write chooses the lowest-numbered unlocked entry. In the same cycle it clears the used bit of every other unlocked entry and leaves locked entries unchanged.
- R7: If every entry is valid and locked, a data-in write changes no entry and produces no flush. full_err is high for exactly the one cycle after the write.
- R8: A data-in or indexed write with address bit 9 set changes no entry and raises neither flush_valid nor full_err.
- R9: When a write replaces an entry whose valid bit was set, flush_valid is high for the one cycle after the write. flush_len is then 8192 << (3 × p), where p is the old word's bits [62:61], and flush_base is the old tag ANDed with the negation of (flush_len − 1). A write into an invalid entry produces no flush.
- R10: A demap request sets the tag and translation word to zero in every valid entry for which (tag XOR demap_va) AND NOT(len − 1) is zero, where len is that entry's page size. A demap never raises flush_valid.
- R11: When strobes coincide, demap takes precedence over an indexed write, and an indexed write takes precedence over a data-in write. The losing strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tag_we | input | 1 | Load the tag-access register |
| tag_wdata | input | VA_W | Value for the tag-access register |
| din_we | input | 1 | Data-in write strobe (victim chosen by the block) |
| idx_we | input | 1 | Indexed write strobe |
| wr_addr | input | WA_W | Write address: bits [8:3] select the entry, bit 9 marks a write to be ignored |
| wr_data | input | TTE_W | Translation word to store |
| demap_we | input | 1 | Demap strobe |
| demap_va | input | VA_W | Virtual address to demap |
| rd_idx | input | IDX_W | Entry selected on the read port |
| rd_tag | output | VA_W | Tag of the selected entry |
| rd_tte | output | TTE_W | Translation word of the selected entry |
| flush_valid | output | 1 | One-cycle pulse: an evicted valid range is reported |
| flush_base | output | VA_W | Base address of the evicted range |
| flush_len | output | VA_W | Length of the evicted range in bytes |
| full_err | output | 1 | One-cycle pulse: a data-in write found no replaceable entry |

## Verification
Several properties are checked on every cycle. A data-in write never lands on a valid entry while an invalid one exists, and never lands on a locked entry. Every flush range is a power of two with an aligned base. Demap, ignored writes and idle cycles never produce a flush, and an error pulse always follows a data-in write. Locked entries change only through an explicit write or a demap. The bench scenarios show what these properties cannot: the exact victim order across a full sweep of all 64 entries, the clearing of used bits when the search wraps, and the flush base and length for each page size. They also show which entries a demap removes and how coinciding strobes resolve.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Operation decoded for the current cycle, after priority resolution
  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_DATA_IN = 2'd1,
    OP_INDEXED = 2'd2,
    OP_DEMAP   = 2'd3
  } tlb_op_e;

  // Each step of the page-size code multiplies the page by eight
  localparam int unsigned SIZE_STEP = 3;

  function automatic int unsigned page_shift(input int unsigned base_lsb,
                                             input logic [1:0] code);
    return base_lsb + SIZE_STEP * int'(code);
  endfunction

endpackage

// File: rtl/tlb_page_span.sv
module tlb_page_span
  import tlb_pkg::*;
#(
  parameter int VA_W     = 64,
  parameter int PAGE_LSB = 13
) (
  input  logic [VA_W-1:0] va_i,
  input  logic [1:0]      code_i,
  output logic [VA_W-1:0] len_o,
  output logic [VA_W-1:0] base_o
);

  localparam logic [VA_W-1:0] ONE = {{(VA_W-1){1'b0}}, 1'b1};

  always_comb begin
    len_o  = ONE << page_shift(PAGE_LSB, code_i);
    base_o = va_i & ~(len_o - ONE);
  end

endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ENTRIES-1:0] lock_i,
  input  logic [ENTRIES-1:0] used_i,
  output logic [IDX_W-1:0]   vic_idx_o,
  output logic               vic_ok_o,
  output logic               vic_wrap_o
);

  function automatic logic [IDX_W-1:0] lowest_set(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  logic [ENTRIES-1:0] empty_v;
  logic [ENTRIES-1:0] fresh_v;
  logic [ENTRIES-1:0] unlocked_v;

  always_comb begin
    empty_v    = ~valid_i;
    unlocked_v = valid_i & ~lock_i;
    fresh_v    = unlocked_v & ~used_i;
    vic_ok_o   = 1'b1;
    vic_wrap_o = 1'b0;
    if (|empty_v) begin
      vic_idx_o = lowest_set(empty_v);
    end else if (|fresh_v) begin
      vic_idx_o = lowest_set(fresh_v);
    end else if (|unlocked_v) begin
      vic_idx_o  = lowest_set(unlocked_v);
      vic_wrap_o = 1'b1;
    end else begin
      vic_idx_o = '0;
      vic_ok_o  = 1'b0;
    end
  end

endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int ENTRIES  = 64,
  parameter int VA_W     = 64,
  parameter int TTE_W    = 64,
  parameter int LOCK_BIT = 6,
  parameter int USED_BIT = 7,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [VA_W-1:0]    wr_tag_i,
  input  logic [TTE_W-1:0]   wr_tte_i,
  input  logic               clr_used_i,
  input  logic [ENTRIES-1:0] zap_i,
  output logic [VA_W-1:0]    tag_o [ENTRIES],
  output logic [TTE_W-1:0]   tte_o [ENTRIES]
);

  logic [VA_W-1:0]  tag_q [ENTRIES];
  logic [TTE_W-1:0] tte_q [ENTRIES];
  logic [VA_W-1:0]  tag_d [ENTRIES];
  logic [TTE_W-1:0] tte_d [ENTRIES];
  logic             upd_en;

  assign upd_en = wr_en_i | clr_used_i | (|zap_i);

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      tag_d[i] = tag_q[i];
      tte_d[i] = tte_q[i];
      if (zap_i[i]) begin
        tag_d[i] = '0;
        tte_d[i] = '0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(i))) begin
        tag_d[i] = wr_tag_i;
        tte_d[i] = wr_tte_i;
      end else if (clr_used_i && !tte_q[i][LOCK_BIT]) begin
        tte_d[i][USED_BIT] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        tte_q[i] <= '0;
      end
    end else if (upd_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= tag_d[i];
        tte_q[i] <= tte_d[i];
      end
    end
  end

  assign tag_o = tag_q;
  assign tte_o = tte_q;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_lock_chk
      // R6
      locked_entry_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tte_q[g][LOCK_BIT] && !zap_i[g] && !(wr_en_i && (wr_idx_i == IDX_W'(g))))
          |=> $stable(tte_q[g]));
    end
  endgenerate

endmodule

// File: rtl/tlb_lru_store.sv
module tlb_lru_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES   = 64,
  parameter int VA_W      = 64,
  parameter int TTE_W     = 64,
  parameter int WA_W      = 10,
  parameter int IDX_LSB   = 3,
  parameter int REAL_BIT  = 9,
  parameter int VALID_BIT = 63,
  parameter int PS_LSB    = 61,
  parameter int LOCK_BIT  = 6,
  parameter int USED_BIT  = 7,
  parameter int PAGE_LSB  = 13,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tag_we,
  input  logic [VA_W-1:0]  tag_wdata,
  input  logic             din_we,
  input  logic             idx_we,
  input  logic [WA_W-1:0]  wr_addr,
  input  logic [TTE_W-1:0] wr_data,
  input  logic             demap_we,
  input  logic [VA_W-1:0]  demap_va,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [VA_W-1:0]  rd_tag,
  output logic [TTE_W-1:0] rd_tte,
  output logic             flush_valid,
  output logic [VA_W-1:0]  flush_base,
  output logic [VA_W-1:0]  flush_len,
  output logic             full_err
);

  localparam logic [VA_W-1:0] ONE = {{(VA_W-1){1'b0}}, 1'b1};

  logic [VA_W-1:0]    tag_acc_q, tag_acc_d;
  logic [VA_W-1:0]    ent_tag [ENTRIES];
  logic [TTE_W-1:0]   ent_tte [ENTRIES];
  logic [ENTRIES-1:0] ent_valid, ent_lock, ent_used, zap;
  logic [IDX_W-1:0]   vic_idx, tgt_idx;
  logic               vic_ok, vic_wrap;
  logic               wr_real, do_write, clr_used;
  logic               flush_d, err_d;
  logic [VA_W-1:0]    old_len, old_base;
  tlb_op_e            op;
  logic               addr_unused;

  assign wr_real     = wr_addr[REAL_BIT];
  assign addr_unused = ^wr_addr[IDX_LSB-1:0];

  // Operation priority: demap, then indexed, then data-in
  always_comb begin
    if (demap_we)                op = OP_DEMAP;
    else if (idx_we && !wr_real) op = OP_INDEXED;
    else if (idx_we)             op = OP_NONE;
    else if (din_we && !wr_real) op = OP_DATA_IN;
    else                         op = OP_NONE;
  end

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic [VA_W-1:0] e_len, e_base;
      assign ent_valid[g] = ent_tte[g][VALID_BIT];
      assign ent_lock[g]  = ent_tte[g][LOCK_BIT];
      assign ent_used[g]  = ent_tte[g][USED_BIT];
      tlb_page_span #(.VA_W(VA_W), .PAGE_LSB(PAGE_LSB)) u_span (
        .va_i   (ent_tag[g]),
        .code_i (ent_tte[g][PS_LSB +: 2]),
        .len_o  (e_len),
        .base_o (e_base)
      );
      assign zap[g] = (op == OP_DEMAP) && ent_valid[g] &&
                      ((demap_va & ~(e_len - ONE)) == e_base);
    end
  endgenerate

  tlb_victim_pick #(.ENTRIES(ENTRIES)) u_pick (
    .valid_i    (ent_valid),
    .lock_i     (ent_lock),
    .used_i     (ent_used),
    .vic_idx_o  (vic_idx),
    .vic_ok_o   (vic_ok),
    .vic_wrap_o (vic_wrap)
  );

  always_comb begin
    tgt_idx  = (op == OP_INDEXED) ? wr_addr[IDX_LSB +: IDX_W] : vic_idx;
    do_write = (op == OP_INDEXED) || ((op == OP_DATA_IN) && vic_ok);
    clr_used = (op == OP_DATA_IN) && vic_ok && vic_wrap;
    err_d    = (op == OP_DATA_IN) && !vic_ok;
    flush_d  = do_write && ent_valid[tgt_idx];
    tag_acc_d = tag_we ? tag_wdata : tag_acc_q;
  end

  tlb_page_span #(.VA_W(VA_W), .PAGE_LSB(PAGE_LSB)) u_old_span (
    .va_i   (ent_tag[tgt_idx]),
    .code_i (ent_tte[tgt_idx][PS_LSB +: 2]),
    .len_o  (old_len),
    .base_o (old_base)
  );

  tlb_entry_store #(
    .ENTRIES  (ENTRIES),
    .VA_W     (VA_W),
    .TTE_W    (TTE_W),
    .LOCK_BIT (LOCK_BIT),
    .USED_BIT (USED_BIT)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (do_write),
    .wr_idx_i   (tgt_idx),
    .wr_tag_i   (tag_acc_q),
    .wr_tte_i   (wr_data),
    .clr_used_i (clr_used),
    .zap_i      (zap),
    .tag_o      (ent_tag),
    .tte_o      (ent_tte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_acc_q   <= '0;
      flush_valid <= 1'b0;
      flush_base  <= '0;
      flush_len   <= '0;
      full_err    <= 1'b0;
    end else begin
      tag_acc_q   <= tag_acc_d;
      flush_valid <= flush_d;
      full_err    <= err_d;
      if (flush_d) begin
        flush_base <= old_base;
        flush_len  <= old_len;
      end
    end
  end

  assign rd_tag = ent_tag[rd_idx];
  assign rd_tte = ent_tte[rd_idx];

  // R4
  victim_free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_DATA_IN) && !(&ent_valid)) |-> !ent_valid[vic_idx]);

  // R5
  victim_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_DATA_IN) && vic_ok && (&ent_valid)) |-> !ent_lock[vic_idx]);

  // R9
  flush_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> (($countones(flush_len) == 1) && ((flush_base & (flush_len - ONE)) == '0)));

  // R7
  err_after_din_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_err |-> ($past(din_we) && !flush_valid));

  // R8
  real_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_real && !demap_we && (din_we || idx_we)) |=> (!flush_valid && !full_err));

  // R10
  demap_no_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (demap_we || !(din_we || idx_we)) |=> !flush_valid);

endmodule

// File: tb/tlb_lru_store_tb.sv
`timescale 1ns/100ps
module tlb_lru_store_tb;

  localparam int N = 64;

  logic        clk, rst_n;
  logic        tag_we, din_we, idx_we, demap_we;
  logic [63:0] tag_wdata, wr_data, demap_va;
  logic [9:0]  wr_addr;
  logic [5:0]  rd_idx;
  logic [63:0] rd_tag, rd_tte, flush_base, flush_len;
  logic        flush_valid, full_err;

  logic [63:0] m_tag [N];
  logic [63:0] m_tte [N];
  logic [63:0] m_acc;
  int          n_chk, n_fail;

  tlb_lru_store u_dut (
    .clk(clk), .rst_n(rst_n), .tag_we(tag_we), .tag_wdata(tag_wdata),
    .din_we(din_we), .idx_we(idx_we), .wr_addr(wr_addr), .wr_data(wr_data),
    .demap_we(demap_we), .demap_va(demap_va), .rd_idx(rd_idx),
    .rd_tag(rd_tag), .rd_tte(rd_tte), .flush_valid(flush_valid),
    .flush_base(flush_base), .flush_len(flush_len), .full_err(full_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [63:0] mk(input bit v, input int ps, input bit lk,
                                     input bit us, input int pay);
    logic [63:0] t;
    t = '0;
    t[63] = v;
    t[62:61] = 2'(ps);
    t[6] = lk;
    t[7] = us;
    t[39:16] = 24'(pay);
    return t;
  endfunction

  function automatic logic [63:0] tag_of(input int k);
    return 64'h0000_1200_0000_0000 | (64'(k) << 23) | 64'h0000_0000_003F_F000;
  endfunction

  function automatic logic [63:0] len_of(input logic [63:0] t);
    return 64'd8192 << (3 * int'(t[62:61]));
  endfunction

  task automatic check_all(input string req);
    for (int i = 0; i < N; i++) begin
      rd_idx = 6'(i);
      #1;
      chk({req, " tag"}, rd_tag, m_tag[i]);
      chk({req, " word"}, rd_tte, m_tte[i]);
    end
  endtask

  task automatic set_tag(input logic [63:0] v);
    tag_we = 1'b1;
    tag_wdata = v;
    tick();
    tag_we = 1'b0;
    m_acc = v;
  endtask

  task automatic exp_flush(input string req, input bit f, input logic [63:0] otag,
                           input logic [63:0] otte);
    logic [63:0] ln;
    ln = len_of(otte);
    chk({req, " flush_valid"}, 64'(flush_valid), 64'(f));
    if (f) begin
      chk({req, " flush_len"}, flush_len, ln);
      chk({req, " flush_base"}, flush_base, otag & ~(ln - 64'd1));
    end
  endtask

  task automatic ixw(input string req, input int idx, input bit real_w, input logic [63:0] d);
    logic [63:0] ot, ow;
    ot = m_tag[idx];
    ow = m_tte[idx];
    wr_addr = {real_w, 6'(idx), 3'b101};
    wr_data = d;
    idx_we = 1'b1;
    tick();
    idx_we = 1'b0;
    exp_flush(req, !real_w && ow[63], ot, ow);
    chk({req, " full_err"}, 64'(full_err), 64'd0);
    if (!real_w) begin
      m_tag[idx] = m_acc;
      m_tte[idx] = d;
    end
  endtask

  task automatic din(input string req, input bit real_w, input logic [63:0] d);
    int v;
    bit wrap;
    logic [63:0] ot, ow;
    v = -1;
    wrap = 1'b0;
    for (int i = N - 1; i >= 0; i--) if (!m_tte[i][63]) v = i;
    if (v < 0) for (int i = N - 1; i >= 0; i--) if (!m_tte[i][6] && !m_tte[i][7]) v = i;
    if (v < 0) begin
      for (int i = N - 1; i >= 0; i--) if (!m_tte[i][6]) v = i;
      wrap = (v >= 0);
    end
    wr_addr = {real_w, 6'd0, 3'b000};
    wr_data = d;
    din_we = 1'b1;
    tick();
    din_we = 1'b0;
    if (real_w) begin
      chk({req, " flush_valid"}, 64'(flush_valid), 64'd0);
      chk({req, " full_err"}, 64'(full_err), 64'd0);
    end else if (v < 0) begin
      chk({req, " flush_valid"}, 64'(flush_valid), 64'd0);
      chk({req, " full_err"}, 64'(full_err), 64'd1);
    end else begin
      ot = m_tag[v];
      ow = m_tte[v];
      exp_flush(req, ow[63], ot, ow);
      chk({req, " full_err"}, 64'(full_err), 64'd0);
      if (wrap) for (int i = 0; i < N; i++) if (!m_tte[i][6]) m_tte[i][7] = 1'b0;
      m_tag[v] = m_acc;
      m_tte[v] = d;
    end
  endtask

  task automatic model_demap(input logic [63:0] va);
    logic [63:0] ln;
    for (int i = 0; i < N; i++) begin
      ln = len_of(m_tte[i]);
      if (m_tte[i][63] && (((m_tag[i] ^ va) & ~(ln - 64'd1)) == 64'd0)) begin
        m_tag[i] = '0;
        m_tte[i] = '0;
      end
    end
  endtask

  task automatic demap(input string req, input logic [63:0] va);
    demap_va = va;
    demap_we = 1'b1;
    tick();
    demap_we = 1'b0;
    chk({req, " flush_valid"}, 64'(flush_valid), 64'd0);
    model_demap(va);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    tag_we = 0; din_we = 0; idx_we = 0; demap_we = 0;
    tag_wdata = '0; wr_data = '0; demap_va = '0; wr_addr = '0; rd_idx = '0;
    m_acc = '0;
    for (int i = 0; i < N; i++) begin m_tag[i] = '0; m_tte[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 flush_valid", 64'(flush_valid), 64'd0);
    chk("R1 full_err", 64'(full_err), 64'd0);
    check_all("R1");

    // R4 fill from empty: each data-in lands in the lowest invalid slot; R2 tag carried
    for (int i = 0; i < N; i++) begin
      set_tag(tag_of(i));
      din("R4 fill", 1'b0, mk(1, i % 4, 0, 0, i));
    end
    check_all("R4 R2 after fill");

    // R3 R9 indexed overwrite of valid entries 0..2 with locked words
    for (int i = 0; i < 3; i++) begin
      set_tag(tag_of(100 + i));
      ixw("R3 R9 lock", i, 1'b0, mk(1, 3 - i, 1, 1, 200 + i));
    end

    // R5 lowest unlocked unused entry
    set_tag(tag_of(110));
    din("R5 first unused", 1'b0, mk(1, 1, 0, 0, 300));
    for (int i = 4; i < 10; i++) begin
      set_tag(tag_of(120 + i));
      ixw("R9 mark used", i, 1'b0, mk(1, i % 4, 0, 1, 400 + i));
    end
    set_tag(tag_of(140));
    din("R5 skip used", 1'b0, mk(1, 2, 0, 0, 500));
    check_all("R5");

    // R6 every unlocked entry used: wrap and clear
    for (int i = 3; i < N; i++) begin
      set_tag(tag_of(150 + i));
      ixw("R9 all used", i, 1'b0, mk(1, i % 4, 0, 1, 600 + i));
    end
    set_tag(tag_of(230));
    din("R6 wrap", 1'b0, mk(1, 0, 0, 1, 700));
    check_all("R6");

    // R8 writes with the ignore bit
    set_tag(tag_of(240));
    ixw("R8 indexed", 5, 1'b1, mk(1, 2, 1, 0, 800));
    din("R8 data-in", 1'b1, mk(1, 2, 1, 0, 801));
    check_all("R8");

    // R7 every entry locked
    for (int i = 0; i < N; i++) begin
      set_tag(tag_of(250 + i));
      ixw("R9 lock all", i, 1'b0, mk(1, i % 4, 1, i % 2, 900 + i));
    end
    din("R7 full", 1'b0, mk(1, 0, 0, 0, 1000));
    tick();
    chk("R7 err one cycle", 64'(full_err), 64'd0);
    din("R8 full but ignored", 1'b1, mk(1, 0, 0, 0, 1001));
    check_all("R7");

    // R10 demap: last byte of entry 20's page, then an address that hits nothing
    demap("R10 hit", (m_tag[20] & ~(len_of(m_tte[20]) - 64'd1)) + len_of(m_tte[20]) - 64'd1);
    demap("R10 miss", 64'hFFFF_0000_0000_0000);
    check_all("R10");

    // R11 demap beats indexed; indexed beats data-in
    demap_va = m_tag[31];
    demap_we = 1'b1;
    idx_we = 1'b1;
    wr_addr = {1'b0, 6'd30, 3'b000};
    wr_data = mk(1, 1, 0, 0, 1100);
    tick();
    demap_we = 1'b0;
    idx_we = 1'b0;
    chk("R11 demap wins flush", 64'(flush_valid), 64'd0);
    model_demap(m_tag[31]);
    check_all("R11 demap over indexed");

    set_tag(tag_of(400));
    idx_we = 1'b1;
    din_we = 1'b1;
    wr_addr = {1'b0, 6'd40, 3'b000};
    wr_data = mk(1, 2, 1, 0, 1200);
    tick();
    idx_we = 1'b0;
    din_we = 1'b0;
    exp_flush("R11 indexed over data-in", 1'b1, m_tag[40], m_tte[40]);
    chk("R11 no err", 64'(full_err), 64'd0);
    m_tag[40] = m_acc;
    m_tte[40] = mk(1, 2, 1, 0, 1200);
    check_all("R11 indexed over data-in");

    // R4 refill demapped holes lowest first, then full again
    set_tag(tag_of(410));
    din("R4 hole 20", 1'b0, mk(1, 3, 1, 0, 1300));
    set_tag(tag_of(411));
    din("R4 hole 31", 1'b0, mk(1, 0, 1, 0, 1301));
    din("R7 full again", 1'b0, mk(1, 0, 0, 0, 1302));
    check_all("R4 refill");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule